// File: doc/BRIEF.md
# Input Status Register with Sticky Latches

This block watches a group of sixteen asynchronous digital input lines and makes their state readable as a single 32-bit word. Every line first passes through a two-flop synchronizer. The lower half of the word shows the synchronized level of each line as it is now. The upper half shows a sticky event flag for each line. A flag sets whenever its line is seen high, and it stays set until software clears it.

Software reads the word with a one-cycle read strobe. The block captures a snapshot into an output register and holds that snapshot until the next strobe. Software clears flags by writing a mask: each set bit in the low half of the written word clears the matching flag, and bits left at zero have no effect. When a second group of sixteen lines is needed, a second identical instance serves it. Address decoding and the electrical input standards are handled outside the block.

Top module: `insr_top`

## Requirements
- R1: Read-data bits 15..0 report input i at bit i after two synchronizer flops. A level that changes before clock edge k is seen by a read strobe that is captured at edge k+2 or later, and is not seen by a strobe captured at edge k+1.
- R2: Read-data bit 16+i is the sticky flag of input i. It sets one edge after the synchronized input i is high, and it stays set while no clear selects it.
- R3: A write with bit i of write data set clears flag i, provided synchronized input i is low in that cycle.
- R4: Writing 0x0000FFFF clears all sixteen flags in one write.
- R5: A write leaves every flag whose mask bit (write data bits 15..0) is zero unchanged. Write-data bits 31..16 have no effect on any flag.
- R6: When a clear and a synchronized high level fall on the same flag in the same cycle, the flag is set after that edge.
- R7: An input pulse that lasts a single clock cycle sets its flag, and the flag stays set after the input returns low.
- R8: Reset (rst_n low, asynchronous) clears all flags, the synchronizer and the read-data register to zero.
- R9: The read-data register changes only at an edge where the read strobe is high, and otherwise holds the last snapshot.
- R10: A read and a write in the same cycle return the flags as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_raw | input | 16 | Asynchronous input lines |
| wr_en | input | 1 | Write strobe (clear request) |
| wr_data | input | 32 | Write data, bits 15..0 form the clear mask |
| rd_en | input | 1 | Read strobe, captures a snapshot |
| rd_data | output | 32 | Snapshot: flags in 31..16, live levels in 15..0 |

## Verification
The bench reads back to back across a single input change to pin the synchronizer latency and the flag latency. A design with one flop too few or too many would shift the new level into the wrong read. Several cases check that no event is lost: a one-cycle pulse, a clear issued while the input is held high, and a read that coincides with a clear. A design where the clear wins, or that ignores short pulses, would show the flag low in these cases. The bench also writes zero masks that have the upper bits set, to catch a design that decodes the wrong half of the write word. Finally, it issues a reset mid-run after flags have been set, to catch flags that survive reset.

// File: rtl/insr_pkg.sv
package insr_pkg;

    localparam int unsigned INSR_DEF_LINES  = 16;
    localparam int unsigned INSR_DEF_STAGES = 2;

    // Next value of a sticky flag vector: clear selected bits, then set on
    // any high live level so that a coincident event is never lost.
    function automatic logic [INSR_DEF_LINES-1:0] insr_flag_next(
        input logic [INSR_DEF_LINES-1:0] cur,
        input logic [INSR_DEF_LINES-1:0] clr,
        input logic [INSR_DEF_LINES-1:0] lvl
    );
        return (cur & ~clr) | lvl;
    endfunction

endpackage

// File: rtl/insr_sync.sv
module insr_sync #(
    parameter int unsigned LINES  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_i,
    output logic [LINES-1:0] level_o
);

    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][LINES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[LAST];

endmodule

// File: rtl/insr_sticky.sv
module insr_sticky #(
    parameter int unsigned LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] level_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] flag_o
);

    typedef struct packed {
        logic [LINES-1:0] flag;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.flag = (st_q.flag & ~clr_i) | level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R2: a flag that is not selected by a clear stays set
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_o & ~clr_i)) |=>
        ((flag_o & $past(flag_o & ~clr_i)) == $past(flag_o & ~clr_i)));

    // R6: a high level always leaves its flag set, whatever the clear says
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|level_i) |=> ((flag_o & $past(level_i)) == $past(level_i)));

    // R3: a selected flag whose level is low is cleared at the next edge
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~level_i)) |=> ((flag_o & $past(clr_i & ~level_i)) == '0));

endmodule

// File: rtl/insr_top.sv
module insr_top
    import insr_pkg::*;
#(
    parameter int unsigned LINES  = INSR_DEF_LINES,
    parameter int unsigned STAGES = INSR_DEF_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   in_raw,
    input  logic               wr_en,
    input  logic [2*LINES-1:0] wr_data,
    input  logic               rd_en,
    output logic [2*LINES-1:0] rd_data
);

    localparam int unsigned WORD_W = 2 * LINES;

    logic [LINES-1:0] level_w;
    logic [LINES-1:0] flag_w;
    logic [LINES-1:0] clr_w;
    logic             unused_wr_hi;

    assign clr_w        = wr_en ? wr_data[LINES-1:0] : '0;
    assign unused_wr_hi = ^wr_data[WORD_W-1:LINES];

    insr_sync #(
        .LINES  (LINES),
        .STAGES (STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (in_raw),
        .level_o (level_w)
    );

    insr_sticky #(
        .LINES (LINES)
    ) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_w),
        .clr_i   (clr_w),
        .flag_o  (flag_w)
    );

    typedef struct packed {
        logic [WORD_W-1:0] snap;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.snap = {flag_w, level_w};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.snap;

    // R9: without a read strobe the snapshot does not move
    a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_insr_top.sv
module tb_insr_top;

    localparam int unsigned N = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_raw = '0;
    logic            wr_en = 1'b0;
    logic [2*N-1:0]  wr_data = '0;
    logic            rd_en = 1'b0;
    logic [2*N-1:0]  rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [N-1:0] cur_in   = '0;
    logic [N-1:0] exp_flag = '0;

    logic [2*N-1:0] exp_q[$];
    string          tag_q[$];
    logic           pend = 1'b0;

    always #5 clk = ~clk;

    insr_top dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_raw  (in_raw),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    task automatic check(input string tag, input logic [2*N-1:0] act,
                         input logic [2*N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // monitor: a strobe seen at a rising edge is compared at the next falling edge
    always @(posedge clk) pend <= rd_en && rst_n;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                check("scoreboard underflow", rd_data, '1);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // driver tasks: each is entered and left at a falling edge
    task automatic rd_cycle(input string tag, input logic [2*N-1:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_read(input string tag);
        rd_cycle(tag, {exp_flag, cur_in});
        @(negedge clk);
    endtask

    task automatic set_in(input logic [N-1:0] v);
        in_raw   = v;
        cur_in   = v;
        exp_flag = exp_flag | v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_in(input logic [N-1:0] v);
        in_raw = cur_in | v;
        @(negedge clk);
        in_raw   = cur_in;
        exp_flag = exp_flag | v;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_write(input logic [2*N-1:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en    = 1'b0;
        wr_data  = '0;
        exp_flag = (exp_flag & ~d[N-1:0]) | cur_in;
    endtask

    task automatic rd_wr_same(input string tag, input logic [2*N-1:0] d);
        exp_q.push_back({exp_flag, cur_in});
        tag_q.push_back(tag);
        rd_en   = 1'b1;
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        wr_data  = '0;
        exp_flag = (exp_flag & ~d[N-1:0]) | cur_in;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset value", rd_data, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        do_read("R8 first read after reset");

        // R1 latency: change at N0, strobes captured at edges +1, +2, +3
        in_raw = 16'h0005;
        @(negedge clk);
        rd_cycle("R1 level not yet through synchronizer", {16'h0000, 16'h0000});
        rd_cycle("R1 level after two flops, R2 flag not yet", {16'h0000, 16'h0005});
        rd_cycle("R2 flag set one edge later", {16'h0005, 16'h0005});
        @(negedge clk);
        cur_in   = 16'h0005;
        exp_flag = 16'h0005;

        set_in(16'hA000);
        do_read("R1 R2 new pattern, old flags kept");
        set_in(16'h0000);
        do_read("R2 flags stay after inputs drop");

        do_write(32'h0000_0001);
        do_read("R3 clear single flag");

        do_write(32'hFFFF_0000);
        do_read("R5 upper write bits ignored");
        do_write(32'h0000_0000);
        do_read("R5 zero mask leaves flags");

        do_write(32'h0000_FFFF);
        do_read("R4 clear all flags");

        pulse_in(16'h0100);
        do_read("R7 one-cycle pulse captured");

        set_in(16'h0030);
        do_write(32'h0000_0030);
        do_read("R6 set wins over clear while high");
        set_in(16'h0000);
        do_write(32'h0000_0010);
        do_read("R3 clear after input low, other kept");

        rd_wr_same("R10 read returns pre-write flags", 32'h0000_FFFF);
        do_read("R10 write took effect after");

        set_in(16'h5A5A);
        do_write(32'h0000_0F0F);
        do_read("R6 R5 mixed mask with held inputs");
        set_in(16'h0000);
        repeat (5) @(negedge clk);
        check("R9 snapshot held without strobe", rd_data, {16'h5A5A, 16'h5A5A});

        do_read("R2 flags after inputs drop");
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset mid-run clears snapshot", rd_data, '0);
        rst_n    = 1'b1;
        exp_flag = '0;
        repeat (3) @(negedge clk);
        do_read("R8 flags cleared by reset");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard leftover", '0, '1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule